// File: doc/BRIEF.md
# Spare-Column Repair Allocator and Remapper

This block sits beside a memory array that carries a few spare data columns. During self-test it receives failure records, each carrying a per-bit error mask for one read, and marks every column that has shown a mismatch. Each newly failing column is given one spare from a small pool. The resulting assignments form a repair signature, which is presented for nonvolatile storage and can be loaded back at power-up.

In normal operation the same assignments steer the data path. On a write, the bit for a repaired column is copied into its spare. On a read, the spare's bit takes the place of the repaired column's bit. A rerun of the self-test therefore reads good data through the spares. If more distinct columns fail than there are spares, the die is flagged as not repairable.

Top module: `spare_col_repair`

## Requirements
- R1: After reset, no spare is assigned: `sig_o` is zero, and `repaired_o`, `unrepairable_o` and `busy_o` are all low.
- R2: A record is accepted when `fail_valid_i` is high and `busy_o` is low. Every bit set in its `fail_mask_i` marks that data column as failing.
- R3: Each failing column that has no spare gets the lowest-numbered free spare. Columns within one record are served lowest bit first, one per cycle. A column that already owns a spare never takes another one.
- R4: Signature entry k occupies `sig_o[k*5 +: 5]`. Bit 4 of the entry is the valid flag and bits 3:0 hold the replaced column index.
- R5: A failing column that finds no free spare sets `unrepairable_o`. The flag stays set until clear or load, and the existing entries stay unchanged.
- R6: `repaired_o` is high once `test_end_i` has been seen, `busy_o` is low, at least one entry is valid and no overflow has occurred. It is low in every other case.
- R7: `busy_o` rises in the cycle after a record is accepted. It falls after the cycle in which the last new column of that record is handled.
- R8: Write path: `wdata_o[15:0]` equals `wdata_i`. Spare bit `wdata_o[16+k]` equals `wdata_i[col_k]` when entry k is valid, and 0 otherwise.
- R9: Read path: for each valid entry k, `rdata_o[col_k]` equals `rdata_i[16+k]`, and the lowest k wins if two entries name the same column. All other bits of `rdata_o` pass through from `rdata_i[15:0]`.
- R10: `clear_i` removes all entries and clears the overflow, test-end and pending state. It has priority over every other input.
- R11: `sig_load_i` copies `sig_i` into the entries in the R4 layout and clears the overflow. `repaired_o` then reflects whether any loaded entry is valid. Later failures fill only the entries left invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Drop all assignments before a new test run |
| fail_valid_i | input | 1 | Failure record strobe |
| fail_mask_i | input | 16 | Per-column error mask of the record |
| test_end_i | input | 1 | Self-test finished strobe |
| sig_load_i | input | 1 | Load stored signature |
| sig_i | input | 10 | Stored signature to restore |
| sig_o | output | 10 | Current repair signature |
| repaired_o | output | 1 | Repair valid and complete |
| unrepairable_o | output | 1 | Spare pool exhausted |
| busy_o | output | 1 | A record is still being processed |
| wdata_i | input | 16 | Write data from the user side |
| wdata_o | output | 18 | Write data to the array, spares on top |
| rdata_i | input | 18 | Read data from the array, spares on top |
| rdata_o | output | 16 | Corrected read data to the user side |

## Verification
Allocation is tried with four kinds of record:
- A record with a single bit set shows the basic assignment and the signature layout.
- A repeated record on a covered column shows that an owned column never takes a second spare.
- A record with two bits set shows the in-record order and the one-column-per-cycle busy timing.
- A record arriving with the pool full separates overflow from a normal assignment.

The data path is driven with patterns that are all-ones or all-zeros except at the repaired column. This tells a correct steer apart from a pass-through. Finally, a bench array model with a stuck column is written and read before and after repair, which separates a faulty read from a corrected one. A loaded signature with a hole in entry 0 shows that later failures fill the free entry first.

// File: rtl/repair_pkg.sv
package repair_pkg;
  function automatic int col_w(int data_w);
    return (data_w > 1) ? $clog2(data_w) : 1;
  endfunction
  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/col_alloc.sv
module col_alloc #(
  parameter int DATA_W  = 16,
  parameter int SPARE_N = 2,
  localparam int COL_W  = repair_pkg::col_w(DATA_W),
  localparam int SP_W   = repair_pkg::idx_w(SPARE_N)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clear_i,
  input  logic                           load_i,
  input  logic [SPARE_N-1:0]             load_valid_i,
  input  logic [SPARE_N-1:0][COL_W-1:0]  load_col_i,
  input  logic                           rec_valid_i,
  input  logic [DATA_W-1:0]              rec_mask_i,
  input  logic                           test_end_i,
  output logic [SPARE_N-1:0]             valid_o,
  output logic [SPARE_N-1:0][COL_W-1:0]  col_o,
  output logic                           busy_o,
  output logic                           ovf_o,
  output logic                           done_o
);
  logic [SPARE_N-1:0]            valid_q;
  logic [SPARE_N-1:0][COL_W-1:0] col_q;
  logic [DATA_W-1:0]             pend_q, covered, pend_eff, pick_oh;
  logic [COL_W-1:0]              pick_idx;
  logic                          pick_hit, free_hit, ovf_q, done_q;
  logic [SP_W-1:0]               free_idx;

  always_comb begin
    covered = '0;
    for (int k = 0; k < SPARE_N; k++)
      if (valid_q[k]) covered[col_q[k]] = 1'b1;
  end

  assign pend_eff = pend_q & ~covered;

  // lowest pending uncovered column
  always_comb begin
    pick_hit = 1'b0;
    pick_idx = '0;
    for (int i = DATA_W - 1; i >= 0; i--)
      if (pend_eff[i]) begin
        pick_hit = 1'b1;
        pick_idx = COL_W'(i);
      end
  end
  assign pick_oh = pick_hit ? (DATA_W'(1) << pick_idx) : '0;

  // lowest free spare
  always_comb begin
    free_hit = 1'b0;
    free_idx = '0;
    for (int k = SPARE_N - 1; k >= 0; k--)
      if (!valid_q[k]) begin
        free_hit = 1'b1;
        free_idx = SP_W'(k);
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      col_q   <= '0;
      pend_q  <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else if (clear_i) begin
      valid_q <= '0;
      col_q   <= '0;
      pend_q  <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else if (load_i) begin
      valid_q <= load_valid_i;
      col_q   <= load_col_i;
      pend_q  <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b1;
    end else begin
      if (pend_q == '0) begin
        if (rec_valid_i) pend_q <= rec_mask_i;
      end else begin
        pend_q <= pend_eff & ~pick_oh;
        if (pick_hit) begin
          if (free_hit) begin
            valid_q[free_idx] <= 1'b1;
            col_q[free_idx]   <= pick_idx;
          end else begin
            ovf_q <= 1'b1;
          end
        end
      end
      if (test_end_i) done_q <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign col_o   = col_q;
  assign busy_o  = (pend_q != '0);
  assign ovf_o   = ovf_q;
  assign done_o  = done_q;

  p_one_alloc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> $countones(valid_q & ~$past(valid_q)) <= 1);
  p_ovf_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> &$past(valid_q));
  p_ovf_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !clear_i && !load_i |=> ovf_q);

  for (genvar k = 0; k < SPARE_N; k++) begin : g_keep
    p_no_realloc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q[k] && !clear_i && !load_i |=> valid_q[k] && $stable(col_q[k]));
  end
endmodule

// File: rtl/col_remap.sv
module col_remap #(
  parameter int DATA_W  = 16,
  parameter int SPARE_N = 2,
  localparam int COL_W  = repair_pkg::col_w(DATA_W),
  localparam int ARR_W  = DATA_W + SPARE_N
) (
  input  logic [SPARE_N-1:0]            valid_i,
  input  logic [SPARE_N-1:0][COL_W-1:0] col_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [ARR_W-1:0]              wdata_o,
  input  logic [ARR_W-1:0]              rdata_i,
  output logic [DATA_W-1:0]             rdata_o
);
  assign wdata_o[DATA_W-1:0] = wdata_i;

  for (genvar k = 0; k < SPARE_N; k++) begin : g_wr
    assign wdata_o[DATA_W+k] = valid_i[k] ? wdata_i[col_i[k]] : 1'b0;
  end

  // lowest entry wins on duplicate columns
  always_comb begin
    rdata_o = rdata_i[DATA_W-1:0];
    for (int k = SPARE_N - 1; k >= 0; k--)
      if (valid_i[k]) rdata_o[col_i[k]] = rdata_i[DATA_W+k];
  end

  always_comb begin
    if (valid_i[0] === 1'b1 && !$isunknown(col_i[0]) && !$isunknown(rdata_i))
      p_read_spare0_r9: assert (rdata_o[col_i[0]] == rdata_i[DATA_W]);
  end
endmodule

// File: rtl/spare_col_repair.sv
module spare_col_repair #(
  parameter int DATA_W  = 16,
  parameter int SPARE_N = 2,
  localparam int COL_W  = repair_pkg::col_w(DATA_W),
  localparam int ENT_W  = COL_W + 1,
  localparam int SIG_W  = ENT_W * SPARE_N,
  localparam int ARR_W  = DATA_W + SPARE_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              fail_valid_i,
  input  logic [DATA_W-1:0] fail_mask_i,
  input  logic              test_end_i,
  input  logic              sig_load_i,
  input  logic [SIG_W-1:0]  sig_i,
  output logic [SIG_W-1:0]  sig_o,
  output logic              repaired_o,
  output logic              unrepairable_o,
  output logic              busy_o,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ARR_W-1:0]  wdata_o,
  input  logic [ARR_W-1:0]  rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [SPARE_N-1:0]            valid, ld_valid;
  logic [SPARE_N-1:0][COL_W-1:0] col, ld_col;
  logic                          ovf, done;

  for (genvar k = 0; k < SPARE_N; k++) begin : g_sig
    assign ld_valid[k]             = sig_i[k*ENT_W + COL_W];
    assign ld_col[k]               = sig_i[k*ENT_W +: COL_W];
    assign sig_o[k*ENT_W +: ENT_W] = {valid[k], col[k]};
  end

  col_alloc #(.DATA_W(DATA_W), .SPARE_N(SPARE_N)) u_alloc (
    .clk_i, .rst_ni, .clear_i,
    .load_i       (sig_load_i),
    .load_valid_i (ld_valid),
    .load_col_i   (ld_col),
    .rec_valid_i  (fail_valid_i),
    .rec_mask_i   (fail_mask_i),
    .test_end_i,
    .valid_o      (valid),
    .col_o        (col),
    .busy_o,
    .ovf_o        (ovf),
    .done_o       (done)
  );

  col_remap #(.DATA_W(DATA_W), .SPARE_N(SPARE_N)) u_remap (
    .valid_i (valid),
    .col_i   (col),
    .wdata_i, .wdata_o, .rdata_i, .rdata_o
  );

  assign unrepairable_o = ovf;
  assign repaired_o     = done && !busy_o && (valid != '0) && !ovf;

  p_rep_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repaired_o |-> !unrepairable_o && !busy_o);
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> sig_o == '0 && !unrepairable_o && !busy_o);
endmodule

// File: tb/sim_spare_col_repair.sv
module sim_spare_col_repair;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        clear = 1'b0, fval = 1'b0, tend = 1'b0, sload = 1'b0;
  logic [15:0] fmask = '0, wd = '0;
  logic [9:0]  sig_in = '0;
  logic [17:0] rd = '0;
  logic [9:0]  sig;
  logic        rep, unrep, busy;
  logic [17:0] wdo;
  logic [15:0] rdo;
  int          n_chk = 0, n_fail = 0;
  logic        finished = 1'b0;
  logic [17:0] mem [4];

  always #(CLK_NS/2) clk = ~clk;

  spare_col_repair u0 (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .fail_valid_i(fval),
    .fail_mask_i(fmask), .test_end_i(tend), .sig_load_i(sload), .sig_i(sig_in),
    .sig_o(sig), .repaired_o(rep), .unrepairable_o(unrep), .busy_o(busy),
    .wdata_i(wd), .wdata_o(wdo), .rdata_i(rd), .rdata_o(rdo)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] m);
    @(negedge clk); fval = 1'b1; fmask = m;
    @(negedge clk); fval = 1'b0; fmask = '0;
  endtask

  task automatic idle();
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
  endtask

  task automatic pulse_end();
    @(negedge clk); tend = 1'b1;
    @(negedge clk); tend = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic t_reset();
    check(sig == 10'h0, "R1 sig", 32'(sig), 0);
    check({rep, unrep, busy} == 3'b000, "R1 status", 32'({rep, unrep, busy}), 0);
  endtask

  task automatic t_single();
    send(16'h0020);
    check(busy == 1'b1, "R7 busy after accept", 32'(busy), 1);
    @(negedge clk);
    check(busy == 1'b0, "R7 busy drop", 32'(busy), 0);
    check(sig == 10'h015, "R2 R4 entry0 col5", 32'(sig), 32'h15);
  endtask

  task automatic t_repeat();
    send(16'h0020); idle();
    send(16'h0020); idle();
    check(sig == 10'h015, "R3 no second spare", 32'(sig), 32'h15);
    pulse_end();
    check(rep == 1'b1 && unrep == 1'b0, "R6 repaired", 32'({rep, unrep}), 32'h2);
  endtask

  task automatic t_steer();
    wd = 16'h0020; #1;
    check(wdo == 18'h10020, "R8 write steer 1", 32'(wdo), 32'h10020);
    wd = 16'hFFDF; #1;
    check(wdo == 18'h0FFDF, "R8 write steer 0", 32'(wdo), 32'hFFDF);
    rd = 18'h10000; #1;
    check(rdo == 16'h0020, "R9 read spare 1", 32'(rdo), 32'h20);
    rd = 18'h0FFFF; #1;
    check(rdo == 16'hFFDF, "R9 read spare 0", 32'(rdo), 32'hFFDF);
  endtask

  task automatic t_clear();
    do_clear();
    check(sig == 10'h0 && rep == 1'b0, "R10 cleared", 32'({sig, rep}), 0);
    wd = 16'hFFFF; #1;
    check(wdo == 18'h0FFFF, "R8 no steer when invalid", 32'(wdo), 32'hFFFF);
  endtask

  task automatic t_multi();
    send(16'h0204);
    check(busy == 1'b1, "R7 busy cycle1", 32'(busy), 1);
    @(negedge clk);
    check(busy == 1'b1 && sig == 10'h012, "R3 lowest bit first", 32'({busy, sig}), 32'h412);
    @(negedge clk);
    check(busy == 1'b0 && sig == 10'h332, "R3 R4 two entries", 32'({busy, sig}), 32'h332);
  endtask

  task automatic t_overflow();
    send(16'h1000); idle();
    check(unrep == 1'b1, "R5 overflow flag", 32'(unrep), 1);
    check(sig == 10'h332, "R5 entries kept", 32'(sig), 32'h332);
    pulse_end();
    check(rep == 1'b0 && unrep == 1'b1, "R5 R6 not repaired", 32'({rep, unrep}), 1);
  endtask

  task automatic t_load();
    do_clear();
    @(negedge clk); sload = 1'b1; sig_in = 10'h2E0;
    @(negedge clk); sload = 1'b0;
    check(sig == 10'h2E0 && rep == 1'b1 && unrep == 1'b0, "R11 load", 32'({sig, rep, unrep}), 32'hB82);
    send(16'h0008); idle();
    check(sig == 10'h2F3, "R11 fills free entry0", 32'(sig), 32'h2F3);
    rd = 18'h20000; #1;
    check(rdo == 16'h0080, "R9 spare1 to col7", 32'(rdo), 32'h80);
  endtask

  task automatic mem_pass(input string tag, input logic [15:0] exp_ok);
    for (int a = 0; a < 4; a++) begin
      wd = 16'hFFFF; #1;
      mem[a] = wdo & ~18'h00020;
    end
    for (int a = 0; a < 4; a++) begin
      rd = mem[a]; #1;
      check(rdo == exp_ok, tag, 32'(rdo), 32'(exp_ok));
    end
  endtask

  task automatic t_rerun();
    do_clear();
    mem_pass("R9 stuck col seen unrepaired", 16'hFFDF);
    send(16'h0020); idle(); pulse_end();
    check(rep == 1'b1, "R6 rerun repaired", 32'(rep), 1);
    mem_pass("R8 R9 rerun reads good", 16'hFFFF);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_repeat();
    t_steer();
    t_clear();
    t_multi();
    t_overflow();
    t_load();
    t_rerun();
    finish_run();
  end

  initial begin
    #(CLK_NS * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule